// File: doc/BRIEF.md
# Signed Iterative Divider with Selectable Rounding

This block divides one signed two's-complement integer by another. It returns a quotient and a remainder. A run-time mode input picks the rounding rule. In truncating mode the quotient is rounded toward zero, which is the rule the HDL `/` and `%` operators follow. In flooring mode the quotient is rounded toward negative infinity, and the remainder is the matching modulo, so it takes the divisor's sign.

A caller raises `start_i` for one cycle while the block is idle. The operands and the mode are registered on that edge. The core then divides the operand magnitudes, producing one quotient bit per clock. In one final cycle it applies the sign correction and, when flooring is selected, the rounding correction. `done_o` pulses when the results are ready, and the results stay on the outputs until the next operation completes. A zero divisor and the single overflowing case are reported by flags.

Top module: `sdiv_top`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o`, `quotient_o`, `remainder_o`, `div_by_zero_o` and `overflow_o` are all zero.
- R2: A `start_i` pulse seen while `busy_o` is low, with a nonzero divisor, sets `busy_o` from the next cycle on. `done_o` is then high for exactly one cycle: the cycle after the (WIDTH+1)th rising edge following the accepting edge. `busy_o` is low in that cycle.
- R3: A `start_i` seen while `busy_o` is high is ignored. The running operation finishes with its own operands, and no extra `done_o` pulse follows.
- R4: With `mode_i`=0 (truncating), the quotient rounds toward zero and a nonzero remainder has the dividend's sign. Examples: -10/3 gives -3 and -1, and 10/-3 gives -3 and 1.
- R5: With `mode_i`=1 (flooring), the quotient rounds toward negative infinity and a nonzero remainder has the divisor's sign. Examples: -10/3 gives -4 and 2, and 10/-3 gives -4 and -2.
- R6: When both operands have the same sign, both modes give the same results. Examples: 10/3 gives 3 and 1, and -10/-3 gives 3 and -1.
- R7: In flooring mode, an exact division with operands of opposite signs is not adjusted. Example: -9/3 gives -3 and 0.
- R8: A zero divisor sets `div_by_zero_o`, sets `quotient_o` to all ones and `remainder_o` to the dividend, in either mode. `done_o` is high in the cycle right after the accepting edge, and `busy_o` never rises.
- R9: The most negative dividend divided by -1 gives the most negative value as the quotient, with remainder 0, and sets `overflow_o`. This holds in both modes.
- R10: Between `done_o` pulses, `quotient_o`, `remainder_o` and both flags hold their values, whatever the inputs do.
- R11: A normal operation clears both flags, and the two flags are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division when idle |
| mode_i | input | 1 | 0 = truncating, 1 = flooring |
| dividend_i | input | WIDTH | Signed dividend |
| divisor_i | input | WIDTH | Signed divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| quotient_o | output | WIDTH | Signed quotient |
| remainder_o | output | WIDTH | Signed remainder or modulo |
| div_by_zero_o | output | 1 | Last operation had a zero divisor |
| overflow_o | output | 1 | Last operation was the most negative value divided by -1 |

## Verification
The bench targets the cases where the two modes disagree: operands of opposite signs with a nonzero remainder. A design that skipped the flooring correction would return the truncated pair there. A design that corrected unconditionally would break exact divisions such as -9/3. It also drives the most negative dividend over -1, where a faulty sign step would produce a wrong quotient or drop the flag. For a zero divisor, a design that iterated anyway would give a late `done_o` and all-ones garbage in the remainder. A start issued mid-operation is checked too, since a design that accepted it would corrupt the result or pulse `done_o` twice. Random operands over all four sign combinations are checked against wide-integer arithmetic in both modes.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic {
    RND_TRUNC = 1'b0,
    RND_FLOOR = 1'b1
  } rnd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/sdiv_core.sv
// Restoring divider on unsigned magnitudes, one quotient bit per step.
module sdiv_core #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] num_i,
  input  logic [WIDTH-1:0] den_i,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_o
);
  logic [WIDTH-1:0] part_q, acc_q, den_q;
  logic [WIDTH:0]   shifted;
  logic             fits;

  assign shifted = {part_q, acc_q[WIDTH-1]};
  assign fits    = shifted >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q <= '0;
      acc_q  <= '0;
      den_q  <= '0;
    end else if (load_i) begin
      part_q <= '0;
      acc_q  <= num_i;
      den_q  <= den_i;
    end else if (step_i) begin
      part_q <= fits ? WIDTH'(shifted - {1'b0, den_q}) : shifted[WIDTH-1:0];
      acc_q  <= {acc_q[WIDTH-2:0], fits};
    end
  end

  assign quo_o = acc_q;
  assign rem_o = part_q;
endmodule

// File: rtl/sdiv_fixup.sv
// Sign restoration plus optional floor adjustment.
module sdiv_fixup
  import sdiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  rnd_mode_e        mode_i,
  input  logic [WIDTH-1:0] num_i,
  input  logic [WIDTH-1:0] den_i,
  input  logic [WIDTH-1:0] quo_mag_i,
  input  logic [WIDTH-1:0] rem_mag_i,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_o
);
  logic             num_neg, den_neg, signs_differ;
  logic [WIDTH-1:0] quo_t, rem_t;

  assign num_neg      = num_i[WIDTH-1];
  assign den_neg      = den_i[WIDTH-1];
  assign signs_differ = num_neg ^ den_neg;

  always_comb begin
    quo_t = signs_differ ? WIDTH'(0) - quo_mag_i : quo_mag_i;
    rem_t = num_neg ? WIDTH'(0) - rem_mag_i : rem_mag_i;
    quo_o = quo_t;
    rem_o = rem_t;
    if (mode_i == RND_FLOOR && signs_differ && rem_t != '0) begin
      quo_o = quo_t - WIDTH'(1);
      rem_o = rem_t + den_i;
    end
  end
endmodule

// File: rtl/sdiv_top.sv
module sdiv_top
  import sdiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o,
  output logic             div_by_zero_o,
  output logic             overflow_o
);
  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  div_state_e       state_q;
  logic [CNT_W-1:0] step_cnt_q;
  logic [WIDTH-1:0] op_num_q, op_den_q;
  rnd_mode_e        op_mode_q;
  logic             ovf_pend_q;
  logic             accept, den_zero, load, step;
  logic [WIDTH-1:0] num_mag, den_mag, core_quo, core_rem, fix_quo, fix_rem;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign den_zero = (divisor_i == '0);
  assign load     = accept && !den_zero;
  assign step     = (state_q == ST_RUN);
  assign num_mag  = dividend_i[WIDTH-1] ? WIDTH'(0) - dividend_i : dividend_i;
  assign den_mag  = divisor_i[WIDTH-1]  ? WIDTH'(0) - divisor_i  : divisor_i;

  sdiv_core #(.WIDTH(WIDTH)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .num_i  (num_mag),
    .den_i  (den_mag),
    .quo_o  (core_quo),
    .rem_o  (core_rem)
  );

  sdiv_fixup #(.WIDTH(WIDTH)) u_fixup (
    .mode_i    (op_mode_q),
    .num_i     (op_num_q),
    .den_i     (op_den_q),
    .quo_mag_i (core_quo),
    .rem_mag_i (core_rem),
    .quo_o     (fix_quo),
    .rem_o     (fix_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      step_cnt_q    <= '0;
      op_num_q      <= '0;
      op_den_q      <= '0;
      op_mode_q     <= RND_TRUNC;
      ovf_pend_q    <= 1'b0;
      done_o        <= 1'b0;
      quotient_o    <= '0;
      remainder_o   <= '0;
      div_by_zero_o <= 1'b0;
      overflow_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_num_q  <= dividend_i;
          op_den_q  <= divisor_i;
          op_mode_q <= rnd_mode_e'(mode_i);
          if (den_zero) begin
            quotient_o    <= '1;
            remainder_o   <= dividend_i;
            div_by_zero_o <= 1'b1;
            overflow_o    <= 1'b0;
            done_o        <= 1'b1;
          end else begin
            state_q    <= ST_RUN;
            step_cnt_q <= '0;
            ovf_pend_q <= (dividend_i == MOST_NEG) && (divisor_i == '1);
          end
        end
        ST_RUN: begin
          step_cnt_q <= step_cnt_q + CNT_W'(1);
          if (step_cnt_q == LAST_STEP) state_q <= ST_FIX;
        end
        ST_FIX: begin
          quotient_o    <= fix_quo;
          remainder_o   <= fix_rem;
          div_by_zero_o <= 1'b0;
          overflow_o    <= ovf_pend_q;
          done_o        <= 1'b1;
          state_q       <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] quotient_o,
  input logic [WIDTH-1:0] remainder_o,
  input logic             div_by_zero_o,
  input logic             overflow_o,
  input logic [WIDTH-1:0] op_num_q,
  input logic [WIDTH-1:0] op_den_q,
  input logic             op_floor
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  logic past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && divisor_i != '0) |=> (busy_o && !done_o)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R2
  AST_ZERO_DEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && divisor_i == '0) |=> (done_o && div_by_zero_o && !busy_o && quotient_o == '1)); // R8
  AST_TRUNC_REM_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !op_floor && op_den_q != '0 && remainder_o != '0) |-> (remainder_o[WIDTH-1] == op_num_q[WIDTH-1])); // R4
  AST_FLOOR_REM_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_floor && op_den_q != '0 && remainder_o != '0) |-> (remainder_o[WIDTH-1] == op_den_q[WIDTH-1])); // R5
  AST_OVF_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && overflow_o) |-> (quotient_o == MOST_NEG && remainder_o == '0)); // R9
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !done_o) |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_by_zero_o) && $stable(overflow_o))); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(div_by_zero_o && overflow_o)); // R11
endmodule

bind sdiv_top sdiv_checker #(.WIDTH(WIDTH)) u_sdiv_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .divisor_i     (divisor_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .quotient_o    (quotient_o),
  .remainder_o   (remainder_o),
  .div_by_zero_o (div_by_zero_o),
  .overflow_o    (overflow_o),
  .op_num_q      (op_num_q),
  .op_den_q      (op_den_q),
  .op_floor      (op_mode_q == sdiv_pkg::RND_FLOOR)
);

// File: tb/sdiv_top_test.sv
`timescale 1ns/1ps
module sdiv_top_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         mode = 1'b0;
  logic [W-1:0] dvd = '0;
  logic [W-1:0] dvs = '0;
  logic         busy, done, dbz, ovf;
  logic [W-1:0] quo, rem;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  sdiv_top #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .dividend_i(dvd), .divisor_i(dvs), .busy_o(busy), .done_o(done),
    .quotient_o(quo), .remainder_o(rem), .div_by_zero_o(dbz), .overflow_o(ovf)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference built on wide signed integers.
  task automatic ref_div(input int a, input int b, input bit flr,
                         output int q, output int r, output bit z, output bit o);
    z = (b == 0);
    o = (a == -(1 << (W-1))) && (b == -1);
    if (z) begin
      q = -1; r = a;
    end else begin
      q = a / b; r = a % b;
      if (flr && r != 0 && ((r < 0) != (b < 0))) begin
        q = q - 1; r = r + b;
      end
    end
    q = int'($signed(W'(q)));
    r = int'($signed(W'(r)));
  endtask

  // Issue one operation; returns results and edges from acceptance to done.
  task automatic run_op(input int a, input int b, input bit flr,
                        output int q, output int r, output bit z, output bit o, output int lat);
    @(negedge clk);
    start = 1'b1; mode = flr; dvd = W'(a); dvs = W'(b);
    @(negedge clk);
    start = 1'b0; dvd = '0; dvs = '0; mode = 1'b0;
    lat = 0;
    while (!done && lat < 4*W) begin
      @(negedge clk);
      lat = lat + 1;
    end
    q = int'($signed(quo)); r = int'($signed(rem)); z = dbz; o = ovf;
  endtask

  task automatic op_and_check(input string req, input int a, input int b, input bit flr);
    int q, r, lat, eq, er;
    bit z, o, ez, eo;
    run_op(a, b, flr, q, r, z, o, lat);
    ref_div(a, b, flr, eq, er, ez, eo);
    chk(req, q, eq);
    chk(req, r, er);
    chk(req, int'(z), int'(ez));
    chk(req, int'(o), int'(eo));
  endtask

  task automatic t_reset;
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 quotient", int'(quo), 0);
    chk("R1 remainder", int'(rem), 0);
    chk("R1 flags", int'({dbz, ovf}), 0);
  endtask

  task automatic t_latency;
    int q, r, lat;
    bit z, o;
    @(negedge clk);
    start = 1'b1; mode = 1'b0; dvd = W'(50); dvs = W'(7);
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", int'(busy), 1);
    chk("R2 no early done", int'(done), 0);
    lat = 0;
    while (!done && lat < 4*W) begin
      @(negedge clk);
      lat = lat + 1;
    end
    chk("R2 latency", lat, W + 1);
    chk("R2 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk("R2 done one cycle", int'(done), 0);
    q = int'($signed(quo)); r = int'($signed(rem)); z = dbz; o = ovf;
    chk("R2 quotient", q, 7);
    chk("R2 remainder", r, 1);
  endtask

  task automatic t_table;
    op_and_check("R4 -10/3 trunc", -10, 3, 1'b0);
    op_and_check("R4 10/-3 trunc", 10, -3, 1'b0);
    op_and_check("R5 -10/3 floor", -10, 3, 1'b1);
    op_and_check("R5 10/-3 floor", 10, -3, 1'b1);
    op_and_check("R6 10/3 trunc", 10, 3, 1'b0);
    op_and_check("R6 10/3 floor", 10, 3, 1'b1);
    op_and_check("R6 -10/-3 trunc", -10, -3, 1'b0);
    op_and_check("R6 -10/-3 floor", -10, -3, 1'b1);
  endtask

  task automatic t_exact;
    op_and_check("R7 -9/3 floor", -9, 3, 1'b1);
    op_and_check("R7 9/-3 floor", 9, -3, 1'b1);
    op_and_check("R7 0/-5 floor", 0, -5, 1'b1);
  endtask

  task automatic t_div0;
    int q, r, lat;
    bit z, o;
    run_op(-77, 0, 1'b1, q, r, z, o, lat);
    chk("R8 latency", lat, 0);
    chk("R8 quotient all ones", q, -1);
    chk("R8 remainder", r, -77);
    chk("R8 flag", int'(z), 1);
    chk("R8 busy never", int'(busy), 0);
    run_op(45, 0, 1'b0, q, r, z, o, lat);
    chk("R8 trunc remainder", r, 45);
    chk("R8 trunc quotient", q, -1);
  endtask

  task automatic t_overflow;
    int q, r, lat;
    bit z, o;
    for (int m = 0; m < 2; m++) begin
      run_op(-(1 << (W-1)), -1, bit'(m), q, r, z, o, lat);
      chk("R9 quotient", q, -(1 << (W-1)));
      chk("R9 remainder", r, 0);
      chk("R9 flag", int'(o), 1);
      chk("R11 no zero flag", int'(z), 0);
    end
    op_and_check("R11 flags cleared", 100, 9, 1'b0);
  endtask

  task automatic t_busy_ignore;
    int lat;
    @(negedge clk);
    start = 1'b1; mode = 1'b1; dvd = W'(-23); dvs = W'(4);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; mode = 1'b0; dvd = W'(90); dvs = W'(0);
    @(negedge clk);
    start = 1'b0; dvd = '0; dvs = '0;
    lat = 0;
    while (!done && lat < 4*W) begin
      @(negedge clk);
      lat = lat + 1;
    end
    chk("R3 quotient kept", int'($signed(quo)), -6);
    chk("R3 remainder kept", int'($signed(rem)), 1);
    chk("R3 no zero flag", int'(dbz), 0);
    lat = 0;
    for (int i = 0; i < W + 4; i++) begin
      @(negedge clk);
      if (done) lat = lat + 1;
    end
    chk("R3 no extra done", lat, 0);
  endtask

  task automatic t_hold;
    int q0, r0, q, r, lat;
    bit z, o;
    run_op(-55, 6, 1'b1, q0, r0, z, o, lat);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      dvd = W'(i * 17); dvs = W'(3 - i); mode = bit'(i);
    end
    q = int'($signed(quo)); r = int'($signed(rem));
    chk("R10 quotient held", q, q0);
    chk("R10 remainder held", r, r0);
    chk("R10 flags held", int'({dbz, ovf}), 0);
  endtask

  task automatic t_random;
    for (int n = 0; n < 250; n++) begin
      int am, bm;
      am = int'($urandom_range(0, (1 << (W-1)) - 1));
      bm = int'($urandom_range(1, (1 << (W-1)) - 1));
      for (int s = 0; s < 4; s++) begin
        op_and_check((s[0] ^ s[1]) ? "R5 random floor" : "R6 random floor",
                     s[0] ? -am : am, s[1] ? -bm : bm, 1'b1);
        op_and_check("R4 random trunc", s[0] ? -am : am, s[1] ? -bm : bm, 1'b0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_latency;
    t_table;
    t_exact;
    t_div0;
    t_overflow;
    t_busy_ignore;
    t_hold;
    t_random;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule